// File: doc/BRIEF.md
# Open-Row Bank Access Sequencer

This block sits between an in-order stream of memory requests and the command pins of a banked dynamic memory. Each request carries a 31-bit address and a read or write flag. The block turns it into the minimum command sequence. It remembers, for every one of the 32 banks separately, which row is currently latched in that bank's sense amplifiers.

A request that targets the row already open in its bank is a row hit and costs one column command. A request to a different row in a bank with an open row is a row miss: that bank is precharged, the new row is activated, and then the column command goes out. A request to a bank with no open row skips the precharge. Four cycle counts are enforced per bank: activate-to-column delay, precharge-to-activate delay, minimum activate-to-precharge time, and the read latency that places a data-valid strobe after each read. A request stays pending, with ready low, until its column command issues.

Top module: `dram_row_ctrl`

## Requirements
- R1: The request address is split as bank group = bits 30:28, bank = bits 27:26, row = bits 25:10, column = bits 9:0. `cmd_bank` carries {bank group, bank}, `cmd_row` carries the row and `cmd_col` carries the column.
- R2: After reset every bank has no open row, so the first request to any bank issues an activate followed by its column command, with no precharge.
- R3: A request whose row equals the open row of its bank issues only the column command (read code 2, write code 3).
- R4: A request to a bank whose open row differs issues precharge (code 1), then activate (code 0), then the column command, in that order.
- R5: Each bank keeps its own open row, so activity in one bank does not close or change the row open in another.
- R6: A column command to a bank issues no earlier than T_RCD cycles after that bank's activate.
- R7: An activate to a bank issues no earlier than T_RP cycles after that bank's precharge.
- R8: A precharge to a bank issues no earlier than T_RAS cycles after that bank's activate.
- R9: `rd_valid` is high exactly CL cycles after each read command and low in every other cycle.
- R10: `req_ready` is high only in the cycle in which the request's column command issues; requests complete in arrival order.
- R11: Each command issues in the first cycle its bank timing allows, with at most one command per cycle.
- R12: With `req_valid` low, no command issues and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request pending; held with its fields until accepted |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Request address |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_op | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | output | 5 | Bank group and bank of the command |
| cmd_row | output | 16 | Row for an activate |
| cmd_col | output | 10 | Column for a read or write |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
On every cycle the assertions check the per-bank timing windows against the ages kept by each bank: no early column, activate or precharge. They also check that a precharge only targets an open bank and leaves it closed, that ready appears only with a column command, and that an idle request port issues nothing. The exact command order for hits, misses and closed banks, the issue cycles, the read strobe latency, and the independence of banks depend on request history. Only the bench's scenarios can show them, against a reference model of open rows and command times.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_PRE = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } cmd_op_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // A window is met once the cycles since the event reach the limit.
  function automatic logic window_met(input int unsigned age, input int unsigned limit);
    return age >= limit;
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int ROW_W   = 16,
  parameter int AGE_W   = 3,
  parameter int AGE_MAX = 6,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_col,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic [AGE_W-1:0] act_age,
  output logic [AGE_W-1:0] pre_age
);

  localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (do_act) begin
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (do_pre) begin
      is_open  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              act_age <= SAT;
    else if (do_act)         act_age <= AGE_W'(1);
    else if (act_age != SAT) act_age <= act_age + AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_age <= SAT;
    else if (do_pre)         pre_age <= AGE_W'(1);
    else if (pre_age != SAT) pre_age <= pre_age + AGE_W'(1);
  end

  // R6: column only on an open bank after the activate-to-column window
  a_r6_rcd_window: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> (is_open && int'(act_age) >= T_RCD));
  // R7: activate only on a closed bank after the precharge window
  a_r7_rp_window: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!is_open && int'(pre_age) >= T_RP));
  // R8: precharge only after the row has been active long enough
  a_r8_ras_window: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |-> int'(act_age) >= T_RAS);
  // R4: precharge targets an open bank and closes it
  a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |-> is_open ##1 !is_open);

endmodule

// File: rtl/cmd_pick.sv
module cmd_pick
  import dram_rc_pkg::*;
#(
  parameter int AGE_W = 3,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             bank_open,
  input  logic             row_match,
  input  logic [AGE_W-1:0] act_age,
  input  logic [AGE_W-1:0] pre_age,
  output logic             cmd_valid,
  output cmd_op_t          cmd_op,
  output logic             grant
);

  logic col_ok, pre_ok, act_ok;

  assign col_ok = window_met(int'(act_age), T_RCD);
  assign pre_ok = window_met(int'(act_age), T_RAS);
  assign act_ok = window_met(int'(pre_age), T_RP);

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_ACT;
    grant     = 1'b0;
    if (req_valid) begin
      if (bank_open && row_match) begin
        if (col_ok) begin
          cmd_valid = 1'b1;
          cmd_op    = req_write ? OP_WR : OP_RD;
          grant     = 1'b1;
        end
      end else if (bank_open) begin
        if (pre_ok) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_PRE;
        end
      end else if (act_ok) begin
        cmd_valid = 1'b1;
        cmd_op    = OP_ACT;
      end
    end
  end

endmodule

// File: rtl/rd_pipe.sv
module rd_pipe #(
  parameter int CL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  output logic rd_valid
);

  logic [CL-1:0] stage;

  generate
    if (CL == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= rd_issue;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[CL-2:0], rd_issue};
      end
    end
  endgenerate

  assign rd_valid = stage[CL-1];

endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl
  import dram_rc_pkg::*;
#(
  parameter int BG_W  = 3,
  parameter int BK_W  = 2,
  parameter int ROW_W = 16,
  parameter int COL_W = 10,
  parameter int CL    = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [BG_W+BK_W+ROW_W+COL_W-1:0] req_addr,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic [BG_W+BK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 rd_valid
);

  localparam int BANK_W  = BG_W + BK_W;
  localparam int NB      = 1 << BANK_W;
  localparam int AGE_MAX = int'(max3(T_RCD, T_RP, T_RAS));
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  // R1: field split, bank group and bank on top
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_row;
  logic [COL_W-1:0]  sel_col;
  assign sel_bank = req_addr[COL_W+ROW_W +: BANK_W];
  assign sel_row  = req_addr[COL_W +: ROW_W];
  assign sel_col  = req_addr[0 +: COL_W];

  logic             b_open [NB];
  logic [ROW_W-1:0] b_row  [NB];
  logic [AGE_W-1:0] b_act  [NB];
  logic [AGE_W-1:0] b_pre  [NB];

  cmd_op_t op;
  logic    pick_valid, grant;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bank
      logic hit_me;
      assign hit_me = pick_valid && (sel_bank == BANK_W'(i));
      bank_timer #(
        .ROW_W(ROW_W), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_act   (hit_me && op == OP_ACT),
        .do_pre   (hit_me && op == OP_PRE),
        .do_col   (hit_me && (op == OP_RD || op == OP_WR)),
        .row_in   (sel_row),
        .is_open  (b_open[i]),
        .open_row (b_row[i]),
        .act_age  (b_act[i]),
        .pre_age  (b_pre[i])
      );
    end
  endgenerate

  cmd_pick #(
    .AGE_W(AGE_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
  ) u_pick (
    .req_valid (req_valid),
    .req_write (req_write),
    .bank_open (b_open[sel_bank]),
    .row_match (b_row[sel_bank] == sel_row),
    .act_age   (b_act[sel_bank]),
    .pre_age   (b_pre[sel_bank]),
    .cmd_valid (pick_valid),
    .cmd_op    (op),
    .grant     (grant)
  );

  rd_pipe #(.CL(CL)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (pick_valid && op == OP_RD),
    .rd_valid (rd_valid)
  );

  assign req_ready = grant;
  assign cmd_valid = pick_valid;
  assign cmd_op    = op;
  assign cmd_bank  = sel_bank;
  assign cmd_row   = sel_row;
  assign cmd_col   = sel_col;

  // R10: acceptance only together with a column command
  a_r10_ready_on_col: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_valid && (cmd_op == 2'd2 || cmd_op == 2'd3)));
  // R12: an idle request port issues nothing
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!cmd_valid && !req_ready));

endmodule

// File: tb/dram_row_ctrl_test.sv
module dram_row_ctrl_test;

  localparam int PERIOD = 10;
  localparam int CL = 4, T_RCD = 3, T_RP = 3, T_RAS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [30:0] req_addr = '0;
  logic        req_ready, cmd_valid, rd_valid;
  logic [1:0]  cmd_op;
  logic [4:0]  cmd_bank;
  logic [15:0] cmd_row;
  logic [9:0]  cmd_col;

  int checks = 0, fails = 0, cyc = 0;
  int m_open [32], m_row [32], m_act [32], m_pre [32];
  bit rd_at [8192];
  bit done = 0;

  dram_row_ctrl #(.CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_valid(rd_valid)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R9: strobe exactly CL cycles after each read command, low otherwise
  always @(negedge clk) begin
    if (rst_n && !done && cyc >= CL && cyc < 8192)
      chk(rd_valid == rd_at[cyc-CL], "R9 rd_valid", int'(rd_valid), int'(rd_at[cyc-CL]));
  end

  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  // One request; the model predicts op order and exact issue cycles (R2-R8, R11)
  task automatic do_req(input bit wr, input int bg, input int bk, input int row,
                        input int col, input string tag);
    int b, n, k, t, g;
    int e_op [3], e_cy [3];
    b = bg * 4 + bk;
    n = 0;
    t = cyc;
    if (m_open[b] != 0 && m_row[b] == row) begin
      e_op[0] = wr ? 3 : 2; e_cy[0] = mx(t, m_act[b] + T_RCD); n = 1;
    end else begin
      if (m_open[b] != 0) begin
        e_op[n] = 1; e_cy[n] = mx(t, m_act[b] + T_RAS);
        m_pre[b] = e_cy[n]; t = e_cy[n] + 1; n++;
      end
      e_op[n] = 0; e_cy[n] = mx(t, m_pre[b] + T_RP);
      m_act[b] = e_cy[n]; n++;
      e_op[n] = wr ? 3 : 2; e_cy[n] = m_act[b] + T_RCD; n++;
    end
    m_open[b] = 1; m_row[b] = row;

    req_write = wr;
    req_addr  = {3'(bg), 2'(bk), 16'(row), 10'(col)};  // R1 layout
    req_valid = 1'b1;
    k = 0;
    g = 0;
    forever begin
      #1;
      if (cmd_valid) begin
        if (k >= n) chk(0, {tag, " extra command"}, int'(cmd_op), -1);
        else begin
          chk(int'(cmd_op) == e_op[k], {tag, " op order"}, int'(cmd_op), e_op[k]);
          chk(cyc == e_cy[k], {tag, " R11 issue cycle"}, cyc, e_cy[k]);
          chk(int'(cmd_bank) == b, {tag, " R1 bank field"}, int'(cmd_bank), b);
          if (e_op[k] == 0)
            chk(int'(cmd_row) == row, {tag, " R1 row field"}, int'(cmd_row), row);
          if (e_op[k] >= 2)
            chk(int'(cmd_col) == col, {tag, " R1 col field"}, int'(cmd_col), col);
        end
        if (cmd_op == 2'd2 && cyc < 8192) rd_at[cyc] = 1'b1;
        k++;
      end
      if (req_ready) begin
        chk(cmd_valid && cmd_op[1], {tag, " R10 ready with column"}, int'(cmd_op), 2);
        break;
      end
      g++;
      if (g > 100) begin
        chk(0, {tag, " R10 request never accepted"}, 0, 1);
        break;
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk(k == n, {tag, " command count"}, k, n);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      #1;
      chk(!cmd_valid && !req_ready, "R12 idle no command", int'(cmd_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_open[i] = 0; m_row[i] = 0; m_act[i] = -1000; m_pre[i] = -1000;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!req_ready && !cmd_valid && !rd_valid, "reset outputs low", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check(3);                                   // R12
    do_req(0, 2, 1, 16'h6B84, 10'h257, "R2 first read");
    do_req(0, 2, 1, 16'h6B84, 10'h258, "R3 hit read");
    do_req(1, 2, 1, 16'h6B84, 10'h001, "R3 hit write");
    do_req(1, 2, 1, 16'h0011, 10'h3FF, "R4 R6 R7 R8 miss write");
    do_req(0, 7, 3, 16'hFFFF, 10'h000, "R2 R5 other bank");
    do_req(0, 0, 0, 16'h0000, 10'h155, "R2 R5 bank zero");
    do_req(0, 2, 1, 16'h0011, 10'h020, "R5 hit kept open");
    do_req(0, 7, 3, 16'hFFFF, 10'h021, "R5 hit other bank");
    do_req(0, 0, 0, 16'h0001, 10'h002, "R8 early miss");
    do_req(0, 0, 0, 16'h0002, 10'h003, "R7 R8 thrash");
    idle_check(8);
    do_req(1, 0, 0, 16'h0002, 10'h004, "R3 hit after idle");
    do_req(0, 0, 0, 16'h0003, 10'h005, "R4 miss after idle");
    repeat (CL + 2) @(negedge clk);
    finish_run();
  end

endmodule